// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block sits beside a processor core and arbitrates sixteen interrupt lines. Line 0 is a reset request that no enable can block. Line 1 is a non-maskable request, gated only by its own enable bit, the NMI-enable. Lines 2 and 3 are reserved maskable lines, which only software can raise. Lines 4 to 15 are maskable lines. Each of them is fed by one of the peripheral event inputs, picked through a per-line select register. A rising edge on a source latches a bit in the pending-flag register. Software can also force flags on or off through separate set and clear registers.

Each cycle the controller finds the lowest-numbered pending line that is eligible. On the next clock edge it takes that line. It pulses `take_o`, presents the line number and a vector address, and clears that line's flag. It also copies the global enable into a saved bit, clears the global enable, and captures the current program counter as the return address. A return-from-interrupt strobe restores the global enable from the saved bit. Vector entries are 32 bytes apart. They sit on top of a table base whose low bits are forced to zero, because the table is sixteen entries of eight 32-bit words.

All registers are reached through a simple single-cycle write strobe and a combinational read port.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset `take_o` is 0 and the pending flags read 0. CSR reads 0 and the table base reads 0. The enable register reads 0x0001, because bit 0 always reads 1.
- R2: Each line n from 4 to 15 has a 5-bit select register at address 16+n. Its reset value is n-4. A rising edge of `evt_in[select]` sets flag n one edge later. An event held high sets nothing more.
- R3: A line from 2 to 15 is taken only when CSR bit 0 (global enable) is 1, enable bit 1 (NMI-enable) is 1, and the line's own enable bit is 1.
- R4: Among eligible pending lines, the lowest line number is taken.
- R5: Line 0 is taken whenever its flag is set, whatever the enables. Line 1 is taken when its flag is set and enable bit 1 is 1, whatever the global enable. The `rst_irq_in` and `nmi_in` rising edges set flags 0 and 1.
- R6: Once a flag is visible, `take_o` is 1 for one cycle after the next edge, with `take_line_o` set to the line. In that same edge four things happen. The line's flag is cleared. CSR bit 1 (saved enable) receives the old global enable. The global enable is cleared. The return register (address 5) loads `pc_in`.
- R7: While `take_o` is 1, `vec_addr_o` equals (table base with bits 8..0 forced to 0) plus 32 times the line number. The table base is written at address 6.
- R8: A `rti_in` strobe with no take in the same cycle loads the global enable from the saved bit.
- R9: The flag register reads at address 2. Writing 1-bits at address 3 sets those flags, and writing 1-bits at address 4 clears them. Bits written as 0 leave their flags alone.
- R10: A hardware edge on a line wins over a clear in the same cycle, whether that clear comes from a take or from a clear-register write. The flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rst_irq_in | input | 1 | Reset-request line (line 0), edge sensitive |
| nmi_in | input | 1 | Non-maskable request (line 1), edge sensitive |
| evt_in | input | 32 | Peripheral event levels |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| pc_in | input | 32 | Current program counter |
| rti_in | input | 1 | Return-from-interrupt strobe |
| take_o | output | 1 | One-cycle pulse when a line is taken |
| take_line_o | output | 4 | Number of the taken line |
| vec_addr_o | output | 32 | Vector address of the taken line |

## Verification
The hard case is a take that clears a line's flag in the same cycle as a fresh hardware edge on that same line. To provoke it, the bench raises the flag through the set register and lifts the mapped event level so that its edge lands on the take edge. It then expects the take pulse and a flag that is still set. The same collision is forced between a clear-register write and an event edge. A return strobe then has to re-take the surviving flag. A seeded random phase checks the winning line and vector against a bench priority function across random enables, global-enable values and pending sets.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;

   // register addresses
   localparam logic [4:0] A_CSR  = 5'd0;
   localparam logic [4:0] A_IER  = 5'd1;
   localparam logic [4:0] A_IFR  = 5'd2;
   localparam logic [4:0] A_ISET = 5'd3;
   localparam logic [4:0] A_ICLR = 5'd4;
   localparam logic [4:0] A_IRP  = 5'd5;
   localparam logic [4:0] A_BASE = 5'd6;
   localparam int unsigned A_SEL0 = 16;

   // fixed line roles
   localparam int unsigned LINE_RST = 0;
   localparam int unsigned LINE_NMI = 1;

endpackage

// File: rtl/irq_src_map.sv
module irq_src_map #(
   parameter int unsigned NUM_LINES  = 16,
   parameter int unsigned FIRST_MASK = 4,
   parameter int unsigned NUM_EVT    = 32,
   parameter int unsigned SEL_W      = 5
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic [NUM_EVT-1:0]               evt_in,
   input  logic [NUM_LINES-1:0]             sel_we,
   input  logic [SEL_W-1:0]                 sel_wdata,
   output logic [NUM_LINES-1:0][SEL_W-1:0]  sel_o,
   output logic [NUM_LINES-1:0]             rise_o
);

   generate
      if (SEL_W < $clog2(NUM_EVT)) begin : g_bad_sel
         $error("irq_src_map: SEL_W too narrow for NUM_EVT");
      end

      for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
         if (l >= FIRST_MASK) begin : g_mapped
            localparam logic [SEL_W-1:0] SEL_RST = SEL_W'((l - FIRST_MASK) % NUM_EVT);
            logic [SEL_W-1:0] sel_q;
            logic             lvl_prev_q;
            logic             lvl;

            always_comb begin
               lvl = 1'b0;
               if (32'(sel_q) < NUM_EVT) lvl = evt_in[sel_q];
            end

            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  sel_q      <= SEL_RST;
                  lvl_prev_q <= 1'b0;
               end else begin
                  if (sel_we[l]) sel_q <= sel_wdata;
                  lvl_prev_q <= lvl;
               end
            end

            assign sel_o[l]  = sel_q;
            assign rise_o[l] = lvl & ~lvl_prev_q;

            // a level that was already high under an unchanged selector gives no edge
            p_level_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
               ($past(lvl) && $stable(sel_q)) |-> !rise_o[l]);
         end else begin : g_fixed
            assign sel_o[l]  = '0;
            assign rise_o[l] = 1'b0;
         end
      end
   endgenerate

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
   parameter int unsigned NUM_LINES = 16,
   parameter int unsigned LINE_W    = 4
) (
   input  logic [NUM_LINES-1:0] req_i,
   output logic                 valid_o,
   output logic [LINE_W-1:0]    idx_o,
   output logic [NUM_LINES-1:0] grant_o
);

   always_comb begin
      valid_o = 1'b0;
      idx_o   = '0;
      for (int i = NUM_LINES - 1; i >= 0; i--) begin
         if (req_i[i]) begin
            valid_o = 1'b1;
            idx_o   = LINE_W'(i);
         end
      end
      grant_o = '0;
      if (valid_o) grant_o[idx_o] = 1'b1;
   end

endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl #(
   parameter int unsigned NUM_LINES   = 16,
   parameter int unsigned FIRST_MASK  = 4,
   parameter int unsigned NUM_EVT     = 32,
   parameter int unsigned ADDR_W      = 32,
   parameter int unsigned STRIDE_LOG2 = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               rst_irq_in,
   input  logic               nmi_in,
   input  logic [NUM_EVT-1:0] evt_in,
   input  logic               reg_wr,
   input  logic [4:0]         reg_addr,
   input  logic [ADDR_W-1:0]  reg_wdata,
   output logic [ADDR_W-1:0]  reg_rdata,
   input  logic [ADDR_W-1:0]  pc_in,
   input  logic               rti_in,
   output logic               take_o,
   output logic [3:0]         take_line_o,
   output logic [ADDR_W-1:0]  vec_addr_o
);
   import irq_vec_pkg::*;

   localparam int unsigned LINE_W     = 4;
   localparam int unsigned SEL_W      = $clog2(NUM_EVT);
   localparam int unsigned TABLE_LOG2 = LINE_W + STRIDE_LOG2;
   localparam int unsigned NL         = NUM_LINES;

   generate
      if (NUM_LINES > 16 || NUM_LINES <= FIRST_MASK || FIRST_MASK < 2) begin : g_bad_lines
         $error("irq_vec_ctrl: line count or first maskable line out of range");
      end
      if (ADDR_W < NUM_LINES || ADDR_W <= TABLE_LOG2 || SEL_W > 32) begin : g_bad_addr
         $error("irq_vec_ctrl: ADDR_W too narrow");
      end
   endgenerate

   // state
   logic                       gie_q, pgie_q;
   logic [NL-1:0]              ier_q, ifr_q, ifr_nxt;
   logic [ADDR_W-1:0]          irp_q;
   logic [ADDR_W-TABLE_LOG2-1:0] base_q;
   logic                       take_q;
   logic [LINE_W-1:0]          line_q;
   logic                       rst_prev_q, nmi_prev_q;

   // write decode
   logic wr_csr, wr_ier, wr_set, wr_clr, wr_irp, wr_base;
   logic [NL-1:0] sel_we;

   assign wr_csr  = reg_wr && (reg_addr == A_CSR);
   assign wr_ier  = reg_wr && (reg_addr == A_IER);
   assign wr_set  = reg_wr && (reg_addr == A_ISET);
   assign wr_clr  = reg_wr && (reg_addr == A_ICLR);
   assign wr_irp  = reg_wr && (reg_addr == A_IRP);
   assign wr_base = reg_wr && (reg_addr == A_BASE);

   always_comb begin
      for (int l = 0; l < NL; l++) begin
         sel_we[l] = reg_wr && (32'(reg_addr) == A_SEL0 + l) && (l >= FIRST_MASK);
      end
   end

   // sources
   logic [NL-1:0][SEL_W-1:0] sel_all;
   logic [NL-1:0]            map_rise;
   logic [NL-1:0]            hw_set;

   irq_src_map #(
      .NUM_LINES (NL),
      .FIRST_MASK(FIRST_MASK),
      .NUM_EVT   (NUM_EVT),
      .SEL_W     (SEL_W)
   ) u_src (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt_in   (evt_in),
      .sel_we   (sel_we),
      .sel_wdata(reg_wdata[SEL_W-1:0]),
      .sel_o    (sel_all),
      .rise_o   (map_rise)
   );

   always_comb begin
      hw_set           = map_rise;
      hw_set[LINE_RST] = rst_irq_in & ~rst_prev_q;
      hw_set[LINE_NMI] = nmi_in & ~nmi_prev_q;
   end

   // eligibility and arbitration
   logic          nmie;
   logic [NL-1:0] elig;
   logic          pick_valid;
   logic [LINE_W-1:0] pick_idx;
   logic [NL-1:0] pick_grant;

   assign nmie = ier_q[LINE_NMI];

   always_comb begin
      for (int l = 0; l < NL; l++) begin
         if (l == LINE_RST)      elig[l] = ifr_q[l];
         else if (l == LINE_NMI) elig[l] = ifr_q[l] & nmie;
         else                    elig[l] = ifr_q[l] & ier_q[l] & gie_q & nmie;
      end
   end

   irq_prio_pick #(
      .NUM_LINES(NL),
      .LINE_W   (LINE_W)
   ) u_pick (
      .req_i  (elig),
      .valid_o(pick_valid),
      .idx_o  (pick_idx),
      .grant_o(pick_grant)
   );

   // flag update: sets (hardware or software) win over clears
   always_comb begin
      ifr_nxt = ifr_q & ~pick_grant;
      if (wr_clr) ifr_nxt = ifr_nxt & ~reg_wdata[NL-1:0];
      ifr_nxt = ifr_nxt | hw_set;
      if (wr_set) ifr_nxt = ifr_nxt | reg_wdata[NL-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gie_q      <= 1'b0;
         pgie_q     <= 1'b0;
         ier_q      <= '0;
         ifr_q      <= '0;
         irp_q      <= '0;
         base_q     <= '0;
         take_q     <= 1'b0;
         line_q     <= '0;
         rst_prev_q <= 1'b0;
         nmi_prev_q <= 1'b0;
      end else begin
         rst_prev_q <= rst_irq_in;
         nmi_prev_q <= nmi_in;
         ifr_q      <= ifr_nxt;
         take_q     <= pick_valid;
         if (pick_valid) begin
            line_q <= pick_idx;
            pgie_q <= gie_q;
            gie_q  <= 1'b0;
            irp_q  <= pc_in;
         end else begin
            if (rti_in) begin
               gie_q <= pgie_q;
            end else if (wr_csr) begin
               gie_q  <= reg_wdata[0];
               pgie_q <= reg_wdata[1];
            end
            if (wr_irp) irp_q <= reg_wdata;
         end
         if (wr_ier)  ier_q  <= reg_wdata[NL-1:0];
         if (wr_base) base_q <= reg_wdata[ADDR_W-1:TABLE_LOG2];
      end
   end

   // outputs
   assign take_o      = take_q;
   assign take_line_o = line_q;
   assign vec_addr_o  = {base_q, line_q, {STRIDE_LOG2{1'b0}}};

   // read port
   logic [3:0] sel_idx;
   assign sel_idx = reg_addr[3:0];

   always_comb begin
      reg_rdata = '0;
      if (reg_addr[4]) begin
         if (32'(sel_idx) < NL) reg_rdata = ADDR_W'(sel_all[sel_idx]);
      end else begin
         case (reg_addr)
            A_CSR:  reg_rdata = ADDR_W'({pgie_q, gie_q});
            A_IER:  reg_rdata = ADDR_W'(ier_q | NL'(1));
            A_IFR:  reg_rdata = ADDR_W'(ifr_q);
            A_IRP:  reg_rdata = irp_q;
            A_BASE: reg_rdata = {base_q, {TABLE_LOG2{1'b0}}};
            default: reg_rdata = '0;
         endcase
      end
   end

   // assertions
   logic [NL-1:0] below_mask;
   assign below_mask = (NL'(1) << line_q) - NL'(1);

   p_irp_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
      take_o |-> (irp_q == $past(pc_in)));

   p_gie_save_r6: assert property (@(posedge clk) disable iff (!rst_n)
      take_o |-> (!gie_q && (pgie_q == $past(gie_q))));

   p_mask_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (take_o && (line_q >= LINE_W'(2))) |-> ($past(gie_q) && $past(ier_q[LINE_NMI])));

   p_nmi_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (take_o && (line_q == LINE_W'(LINE_NMI))) |-> $past(ier_q[LINE_NMI]));

   p_lowest_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
      take_o |-> (($past(elig) & below_mask) == '0));

   p_rti_restore_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rti_in && !pick_valid) |=> (gie_q == $past(pgie_q)));

   p_edge_survives_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (|hw_set) |=> ((ifr_q & $past(hw_set)) == $past(hw_set)));

endmodule

// File: tb/irq_vec_ctrl_test.sv
`timescale 1ns/1ps
module irq_vec_ctrl_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rst_irq_in = 1'b0;
   logic        nmi_in = 1'b0;
   logic [31:0] evt_in = '0;
   logic        reg_wr = 1'b0;
   logic [4:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [31:0] pc_in = '0;
   logic        rti_in = 1'b0;
   logic        take_o;
   logic [3:0]  take_line_o;
   logic [31:0] vec_addr_o;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   localparam logic [4:0] CSR = 5'd0, IER = 5'd1, IFR = 5'd2, ISET = 5'd3,
                          ICLR = 5'd4, IRP = 5'd5, BASE = 5'd6;
   localparam logic [31:0] TBASE = 32'h8000_1200;

   always #2.5 clk = ~clk;

   irq_vec_ctrl uut (
      .clk(clk), .rst_n(rst_n), .rst_irq_in(rst_irq_in), .nmi_in(nmi_in),
      .evt_in(evt_in), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .pc_in(pc_in), .rti_in(rti_in), .take_o(take_o),
      .take_line_o(take_line_o), .vec_addr_o(vec_addr_o)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   // expected winner: -1 when nothing is eligible
   function automatic int exp_pick(input logic [15:0] f, input logic [15:0] en, input bit g);
      for (int i = 0; i < 16; i++) begin
         if (i == 0 && f[0]) return 0;
         if (i == 1 && f[1] && en[1]) return 1;
         if (i >= 2 && f[i] && en[i] && en[1] && g) return i;
      end
      return -1;
   endfunction

   function automatic logic [31:0] exp_vec(input int line);
      return TBASE + 32'(line) * 32;
   endfunction

   task automatic expect_take(input int line, input string req);
      @(negedge clk);
      chk(take_o === 1'b1 && take_line_o == 4'(line), req, {27'd0, take_o, take_line_o}, {27'd0, 1'b1, 4'(line)});
      chk(vec_addr_o == exp_vec(line), req, vec_addr_o, exp_vec(line));
   endtask

   task automatic expect_quiet(input int cycles, input string req);
      for (int i = 0; i < cycles; i++) begin
         @(negedge clk);
         chk(take_o === 1'b0, req, {31'd0, take_o}, 32'd0);
      end
   endtask

   initial begin
      logic [31:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      @(negedge clk);
      chk(take_o === 1'b0, "R1 take", {31'd0, take_o}, 0);
      rd(CSR, d);  chk(d == 0, "R1 csr", d, 0);
      rd(IER, d);  chk(d == 1, "R1 ier", d, 1);
      rd(IFR, d);  chk(d == 0, "R1 ifr", d, 0);
      rd(BASE, d); chk(d == 0, "R1 base", d, 0);
      rd(5'(16 + 9), d); chk(d == 5, "R2 default select line9", d, 5);

      // R2/R6/R7: event 30 mapped to line 5
      wr(BASE, 32'h8000_1234);
      rd(BASE, d); chk(d == TBASE, "R7 base align", d, TBASE);
      wr(5'(16 + 5), 32'd30);
      wr(IER, 32'h0000_0022);
      wr(CSR, 32'd1);
      pc_in = 32'h1000_0040;
      evt_in[30] = 1'b1;
      @(negedge clk);
      chk(take_o === 1'b0, "R6 no take before flag", {31'd0, take_o}, 0);
      expect_take(5, "R2 R6 R7 mapped event take");
      expect_quiet(2, "R6 single pulse");
      rd(IRP, d); chk(d == 32'h1000_0040, "R6 return address", d, 32'h1000_0040);
      rd(CSR, d); chk(d == 2, "R6 saved enable", d, 2);
      rd(IFR, d); chk(d == 0, "R2 held level no new flag", d, 0);
      evt_in[30] = 1'b0;

      // R10: take-clear collides with new edge on line 5
      wr(CSR, 32'd1);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = ISET; reg_wdata = 32'h20;
      @(negedge clk);
      reg_wr = 1'b0; evt_in[30] = 1'b1;
      expect_take(5, "R10 take during edge");
      rd(IFR, d); chk(d[5] == 1'b1, "R10 flag survives take", d, 32'h20);
      evt_in[30] = 1'b0;
      expect_quiet(2, "R8 pending waits for enable");

      // R8: return restores enable, pending flag is taken again
      @(negedge clk); rti_in = 1'b1;
      @(negedge clk); rti_in = 1'b0;
      chk(take_o === 1'b0, "R8 take one edge later", {31'd0, take_o}, 0);
      expect_take(5, "R8 retake after return");

      // R3: NMI-enable and own bit gating
      wr(CSR, 32'd1);
      wr(IER, 32'h0000_0040);
      wr(ISET, 32'h40);
      expect_quiet(3, "R3 blocked by nmie");
      rd(IFR, d); chk(d[6] == 1'b1, "R3 flag pending", d, 32'h40);
      wr(IER, 32'h0000_0042);
      expect_take(6, "R3 taken once nmie set");
      wr(CSR, 32'd1);
      wr(IER, 32'h0000_0002);
      wr(ISET, 32'h80);
      expect_quiet(3, "R3 blocked by own bit");
      wr(CSR, 32'd0);
      wr(IER, 32'h0000_0082);
      expect_quiet(3, "R3 blocked by global enable");
      wr(ICLR, 32'hFFFF);

      // R5: NMI and reset line
      wr(IER, 32'd0);
      @(negedge clk); nmi_in = 1'b1;
      expect_quiet(3, "R5 nmi needs nmie");
      rd(IFR, d); chk(d[1] == 1'b1, "R5 nmi flag", d, 2);
      wr(IER, 32'd2);
      expect_take(1, "R5 nmi with global enable off");
      nmi_in = 1'b0;
      wr(IER, 32'd0);
      @(negedge clk); rst_irq_in = 1'b1;
      @(negedge clk);
      expect_take(0, "R5 reset line unmaskable");
      rst_irq_in = 1'b0;

      // R9: set and clear registers
      wr(ICLR, 32'hFFFF);
      wr(ISET, 32'h0A04);
      rd(IFR, d); chk(d == 32'h0A04, "R9 set", d, 32'h0A04);
      wr(ICLR, 32'h0804);
      rd(IFR, d); chk(d == 32'h0200, "R9 clear", d, 32'h0200);

      // R10: clear write colliding with edge
      wr(ISET, 32'h20);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = ICLR; reg_wdata = 32'h20; evt_in[30] = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0; evt_in[30] = 1'b0;
      rd(IFR, d); chk(d[5] == 1'b1, "R10 edge beats clear write", d, 32'h220);

      // R4: seeded random priority phase
      void'($urandom(32'h5eed_1234));
      for (int it = 0; it < 40; it++) begin
         logic [15:0] en, fl;
         bit g;
         int e;
         wr(CSR, 0);
         wr(IER, 0);
         wr(ICLR, 32'hFFFF);
         repeat (2) @(negedge clk);
         en = 16'($urandom);
         g  = 1'($urandom);
         fl = 16'($urandom);
         if (($urandom % 4) != 0) fl[0] = 1'b0;
         if (fl == 0) fl = 16'h1000;
         pc_in = $urandom;
         wr(IER, {16'd0, en});
         wr(CSR, {31'd0, g});
         wr(ISET, {16'd0, fl});
         e = exp_pick(fl, en, g);
         if (e >= 0) expect_take(e, "R4 random priority");
         else begin
            @(negedge clk);
            chk(take_o === 1'b0, "R4 random none eligible", {31'd0, take_o}, 0);
         end
         repeat (4) @(negedge clk);
      end

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog actual=running expected=done");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule